// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This block serves four external interrupt pins of a small microcontroller. Each pin passes through a two-flop synchroniser, and an edge detector compares the synchronised level with its previous sample. A per-pin polarity bit picks rising or falling edges. A qualifying edge sets a sticky pending flag, and only software clears it. A per-pin enable gates the flag onto one of two registered request outputs, high or low priority. Pins 1 to 3 each carry a priority bit. Pin 0 always goes to the high-priority output.

A small state machine follows the core's sleep signal. On entry to sleep it captures the enables in force at that moment. While the core sleeps, a pending flag on a pin that was enabled at sleep entry raises a wake request. That request holds until the core leaves sleep. The request outputs keep working during sleep, so a core that wakes with interrupts globally enabled finds its request already asserted.

Software reaches the flag, enable, polarity and priority bits through a four-entry register port. Writes are single-cycle and reads are combinational.

Top module: `eiu_ext_irq`

## Requirements
- R1: With polarity bit i (address 2, bit i) at 1, a rising edge on ext_pin[i] sets pending flag i (address 0, bit i).
- R2: With polarity bit i at 0, a falling edge on ext_pin[i] sets flag i, and a rising edge does not.
- R3: A flag stays set until a write to address 0 with bit i at 1 clears it. Writing 0 to a flag bit has no effect.
- R4: No request output is asserted for a pin whose enable bit (address 1, bit i) is 0, even when its flag is set.
- R5: For pins 1 to 3, an enabled pending pin drives irq_hi when its priority bit (address 3, bit i) is 1 and irq_lo when it is 0. Both outputs are registered: they change one cycle after the flag/enable/priority state.
- R6: Pin 0 always requests on irq_hi. Priority bit 0 reads as 0, and writes to it are ignored.
- R7: The sleep state machine has three states. AWAKE goes to ASLEEP when core_sleep rises, capturing the enables. ASLEEP goes to WAKING when a pin enabled in that capture has a pending flag. ASLEEP or WAKING returns to AWAKE when core_sleep is 0. wake_req is high exactly in WAKING. An edge on a pin that was not enabled does not wake the core. irq_hi and irq_lo still follow R5 during sleep.
- R8: If a clear of flag i lands in the same cycle as a new edge on pin i, the flag stays set.
- R9: After reset the flags, enables and priorities are 0, the polarity bits are all 1, and irq_hi, irq_lo and wake_req are 0.
- R10: Detection is edge-only. A level present when reset is released sets no flag, and a pin held at its active level does not set the flag again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| core_sleep | input | 1 | High while the core is in a power-managed mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 enables, 2 polarity, 3 priority |
| reg_wdata | input | 4 | Write data, one bit per pin |
| reg_rdata | output | 4 | Read data of the selected register |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |
| wake_req | output | 1 | Wake request to the sleeping core |

## Verification
Assertions check the following on every cycle:
- a flag stays set unless a clear without a coincident edge removes it;
- an edge always leaves its flag set;
- a clear without a coincident edge empties the flag;
- irq_lo is only asserted when a low-priority pin was enabled and pending, and an enabled pending pin 0 asserts irq_hi;
- wake_req only follows a sleeping core and drops once sleep ends.

Polarity selection, reset-time masking of a held level, the exact cycle where a clear and an edge collide, and the capture of the enables at sleep entry depend on stimulus order. Only the bench's scenarios show these.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    typedef enum logic [1:0] {
        REG_FLAG   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_EDGE   = 2'd2,
        REG_PRIO   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_ASLEEP = 2'd1,
        ST_WAKING = 2'd2
    } sleep_state_e;

endpackage

// File: rtl/eiu_edge_det.sv
module eiu_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic edge_hit
);
    localparam int ARM_LEN = SYNC_STAGES + 1;
    localparam int TOP     = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [ARM_LEN-1:0]     arm_q;
    logic                   level;
    logic                   rise_seen;
    logic                   fall_seen;

    // Synchroniser chain, previous-sample flop and an arming shift register
    // that suppresses detection until the chain holds real pin samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            arm_q  <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[TOP];
            arm_q  <= {arm_q[ARM_LEN-2:0], 1'b1};
        end
    end

    always_comb begin
        level     = sync_q[TOP];
        rise_seen = level & ~prev_q;
        fall_seen = ~level & prev_q;
        edge_hit  = arm_q[ARM_LEN-1] & (rise_sel ? rise_seen : fall_seen);
    end

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int AW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] edge_hit,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic [NUM_PINS-1:0] flags,
    output logic [NUM_PINS-1:0] enables,
    output logic [NUM_PINS-1:0] rise_sel,
    output logic [NUM_PINS-1:0] prio
);
    localparam logic [NUM_PINS-1:0] PRIO_MASK = {{(NUM_PINS-1){1'b1}}, 1'b0};

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] clr_mask;
    logic [NUM_PINS-1:0] flag_q, en_q, edge_q, prio_q;

    always_comb begin
        sel      = reg_sel_e'(reg_addr);
        clr_mask = (reg_wr && sel == REG_FLAG) ? reg_wdata : '0;
    end

    // Flag bank: a new edge overrides a coincident clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_mask) | edge_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            edge_q <= '1;
            prio_q <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                REG_ENABLE: en_q   <= reg_wdata;
                REG_EDGE:   edge_q <= reg_wdata;
                REG_PRIO:   prio_q <= reg_wdata & PRIO_MASK;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_FLAG:   reg_rdata = flag_q;
            REG_ENABLE: reg_rdata = en_q;
            REG_EDGE:   reg_rdata = edge_q;
            REG_PRIO:   reg_rdata = prio_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign flags    = flag_q;
    assign enables  = en_q;
    assign rise_sel = edge_q;
    assign prio     = prio_q;

endmodule

// File: rtl/eiu_wake_fsm.sv
module eiu_wake_fsm
    import eiu_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_sleep,
    input  logic [NUM_PINS-1:0] enables,
    input  logic [NUM_PINS-1:0] flags,
    output logic                wake_req
);
    sleep_state_e        state_q, state_nx;
    logic [NUM_PINS-1:0] snap_q;
    logic                wake_q;
    logic                pending_armed;

    assign pending_armed = |(flags & snap_q);

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_AWAKE:  if (core_sleep) state_nx = ST_ASLEEP;
            ST_ASLEEP: begin
                if (!core_sleep)        state_nx = ST_AWAKE;
                else if (pending_armed) state_nx = ST_WAKING;
            end
            ST_WAKING: if (!core_sleep) state_nx = ST_AWAKE;
            default:   state_nx = ST_AWAKE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_nx;
    end

    // Outputs: enable capture on sleep entry and the registered wake request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            wake_q <= 1'b0;
        end else begin
            if (state_q == ST_AWAKE && state_nx == ST_ASLEEP) snap_q <= enables;
            wake_q <= (state_nx == ST_WAKING);
        end
    end

    assign wake_req = wake_q;

endmodule

// File: rtl/eiu_ext_irq.sv
module eiu_ext_irq
    import eiu_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                core_sleep,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq_hi,
    output logic                irq_lo,
    output logic                wake_req
);
    logic [NUM_PINS-1:0] edge_hit_w;
    logic [NUM_PINS-1:0] flags_w, en_w, rise_w, prio_w;
    logic [NUM_PINS-1:0] hi_map;
    logic [NUM_PINS-1:0] live;
    logic                irq_hi_q, irq_lo_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        eiu_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (ext_pin[g]),
            .rise_sel (rise_w[g]),
            .edge_hit (edge_hit_w[g])
        );
        if (g == 0) begin : g_fixed_hi
            assign hi_map[g] = 1'b1;
        end else begin : g_prog
            assign hi_map[g] = prio_w[g];
        end
    end

    eiu_regs #(.NUM_PINS(NUM_PINS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_hit  (edge_hit_w),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flags     (flags_w),
        .enables   (en_w),
        .rise_sel  (rise_w),
        .prio      (prio_w)
    );

    eiu_wake_fsm #(.NUM_PINS(NUM_PINS)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_sleep (core_sleep),
        .enables    (en_w),
        .flags      (flags_w),
        .wake_req   (wake_req)
    );

    assign live = flags_w & en_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_hi_q <= 1'b0;
            irq_lo_q <= 1'b0;
        end else begin
            irq_hi_q <= |(live & hi_map);
            irq_lo_q <= |(live & ~hi_map);
        end
    end

    assign irq_hi = irq_hi_q;
    assign irq_lo = irq_lo_q;

endmodule

// File: rtl/eiu_ext_irq_chk.sv
module eiu_ext_irq_chk
    import eiu_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int AW       = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] flags_w,
    input logic [NUM_PINS-1:0] en_w,
    input logic [NUM_PINS-1:0] prio_w,
    input logic [NUM_PINS-1:0] edge_hit_w,
    input logic                reg_wr,
    input logic [AW-1:0]       reg_addr,
    input logic [NUM_PINS-1:0] reg_wdata,
    input logic                core_sleep,
    input logic                irq_hi,
    input logic                irq_lo,
    input logic                wake_req
);
    logic [NUM_PINS-1:0] clr;
    logic [NUM_PINS-1:0] keep;
    logic                lo_live;

    assign clr     = (reg_wr && reg_addr == AW'(REG_FLAG)) ? reg_wdata : '0;
    assign keep    = flags_w & ~clr;
    assign lo_live = |(flags_w[NUM_PINS-1:1] & en_w[NUM_PINS-1:1] & ~prio_w[NUM_PINS-1:1]);

    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_w & $past(keep)) == $past(keep)));

    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_w & $past(clr & ~edge_hit_w)) == '0));

    p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit_w) |=> ((flags_w & $past(edge_hit_w)) == $past(edge_hit_w)));

    p_lo_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(lo_live));

    p_pin0_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_w[0] && en_w[0]) |=> irq_hi);

    p_wake_in_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(core_sleep));

    p_wake_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !core_sleep |=> !wake_req);

endmodule

bind eiu_ext_irq eiu_ext_irq_chk #(.NUM_PINS(NUM_PINS), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_w    (flags_w),
    .en_w       (en_w),
    .prio_w     (prio_w),
    .edge_hit_w (edge_hit_w),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .core_sleep (core_sleep),
    .irq_hi     (irq_hi),
    .irq_lo     (irq_lo),
    .wake_req   (wake_req)
);

// File: tb/tb_eiu_ext_irq.sv
`timescale 1ns/1ps
module tb_eiu_ext_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'b0100;
    logic       core_sleep = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic       irq_hi, irq_lo, wake_req;

    int checks = 0;
    int errors = 0;

    // {pins to drive, expected flags}; polarity is 0101 (pins 0,2 rising; 1,3 falling)
    localparam logic [7:0] VEC [0:7] = '{
        8'b0001_0001, 8'b1011_0000, 8'b1111_0100, 8'b0101_1010,
        8'b0000_0000, 8'b1111_0101, 8'b0000_1010, 8'b0110_0100
    };

    always #10 clk = ~clk;

    eiu_ext_irq dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(pins), .core_sleep(core_sleep),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_hi(irq_hi), .irq_lo(irq_lo), .wake_req(wake_req)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] v;
        step(3);
        rst_n = 1'b1;
        // R9 reset state, R10 level held through reset
        step(6);
        rd(2'd0, v); chk("R10 level at reset release flags", v, 4'b0000);
        rd(2'd1, v); chk("R9 enable reset", v, 4'b0000);
        rd(2'd2, v); chk("R9 polarity reset", v, 4'b1111);
        rd(2'd3, v); chk("R9 priority reset", v, 4'b0000);
        chk("R9 outputs reset", {1'b0, irq_hi, irq_lo, wake_req}, 4'b0000);
        // R2 negative: falling edge ignored under default rising polarity
        pins = 4'b0000; step(6);
        rd(2'd0, v); chk("R1 falling ignored when rising selected", v, 4'b0000);
        wr(2'd2, 4'b0101);
        wr(2'd0, 4'b1111);

        // Table walk: R1 and R2 per pin, R4 no request while disabled
        for (int i = 0; i < 8; i++) begin
            pins = VEC[i][7:4];
            step(6);
            rd(2'd0, v); chk($sformatf("R1/R2 vector %0d flags", i), v, VEC[i][3:0]);
            chk($sformatf("R4 vector %0d no request", i), {2'b00, irq_hi, irq_lo}, 4'b0000);
            wr(2'd0, 4'b1111);
        end

        // R8 clear coinciding with a new edge on pin 2
        pins = 4'b0010; step(6); wr(2'd0, 4'b1111);
        pins = 4'b0110; step(6);
        rd(2'd0, v); chk("R1 pin2 flag", v, 4'b0100);
        pins = 4'b0010; step(6);
        pins = 4'b0110;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(2'd0, 4'b0100);
        rd(2'd0, v); chk("R8 edge wins over clear", v, 4'b0100);
        wr(2'd0, 4'b0000);
        rd(2'd0, v); chk("R3 writing 0 keeps flag", v, 4'b0100);
        wr(2'd0, 4'b0100);
        rd(2'd0, v); chk("R3 write 1 clears flag", v, 4'b0000);
        step(10);
        rd(2'd0, v); chk("R10 held level no re-trigger", v, 4'b0000);

        // Priority routing
        pins = 4'b0001; step(6);
        rd(2'd0, v); chk("R1/R2 pin0 and pin1 flags", v, 4'b0011);
        step(2);
        chk("R4 flags set but disabled", {2'b00, irq_hi, irq_lo}, 4'b0000);
        wr(2'd3, 4'b0000); wr(2'd1, 4'b0010); step(2);
        chk("R5 pin1 low priority", {2'b00, irq_hi, irq_lo}, 4'b0001);
        wr(2'd3, 4'b0010); step(2);
        chk("R5 pin1 high priority", {2'b00, irq_hi, irq_lo}, 4'b0010);
        wr(2'd3, 4'b1111);
        rd(2'd3, v); chk("R6 priority bit0 fixed", v, 4'b1110);
        wr(2'd3, 4'b0000); wr(2'd1, 4'b0001); step(2);
        chk("R6 pin0 always high", {2'b00, irq_hi, irq_lo}, 4'b0010);
        wr(2'd0, 4'b1111); wr(2'd1, 4'b0000); step(2);
        chk("R3 cleared flags drop requests", {2'b00, irq_hi, irq_lo}, 4'b0000);

        // R7 wake sequence
        pins = 4'b1011; step(6); wr(2'd0, 4'b1111);
        wr(2'd1, 4'b0010);
        core_sleep = 1'b1; step(3);
        chk("R7 asleep no wake yet", {3'b000, wake_req}, 4'b0000);
        pins = 4'b0011; step(6);
        chk("R7 disabled pin no wake", {3'b000, wake_req}, 4'b0000);
        pins = 4'b0001; step(6);
        chk("R7 enabled pin wakes", {3'b000, wake_req}, 4'b0001);
        chk("R7 request during sleep", {2'b00, irq_hi, irq_lo}, 4'b0001);
        core_sleep = 1'b0; step(2);
        chk("R7 wake drops after sleep ends", {3'b000, wake_req}, 4'b0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule